// File: doc/BRIEF.md
# Magnitude Integrating Attenuator Controller

This block sets a front-end attenuator from the measured signal level. Over each integration window it sums the magnitude samples that arrive with a valid flag. The sum is kept in a wide saturating accumulator. At the end of the window a programmable right shift reduces the sum to a 16-bit level. That level is compared with an upper and a lower threshold, and the 3-bit attenuator code moves by one 6 dB step toward the target. The code then stays inside a programmable pair of limits.

An external timer supplies the window-start and window-end pulses, and the magnitude arrives already computed. The block also forms an exponent for the downstream channel. That exponent is the sum of an optional input exponent and the optional attenuator code. A main enable switches the whole function on or off. A separate update enable freezes the code while integration keeps running.

Top module: `mag_atten_ctrl`

## Requirements
- R1: After reset, `atten_code` is 0 (0 dB) and `exp_out` is 0.
- R2: The accumulator starts from zero in the cycle `win_start` is high. Every cycle it adds `mag` only when `mag_valid` is high, including the `win_start` and `win_end` cycles.
- R3: The accumulator saturates at all ones (2^ACC_W - 1) and never wraps.
- R4: The compared level is the window sum shifted right by `shift_sel + 1`. The input sample bit 0 has weight 2^-15, so code 0 keeps weights 2^1..2^-14 and code 15 keeps weights 2^16..2^1. If the shifted value does not fit in 16 bits, the level is 16'hFFFF.
- R5: At a window end, a level strictly above `thr_hi` raises the code by one step. The new code appears in the cycle after `win_end`.
- R6: At a window end, a level strictly below `thr_lo` (and not above `thr_hi`) lowers the code by one step. Any other level leaves the code unchanged.
- R7: A step never wraps. The code stays at 7 when raised and at 0 when lowered. Code k means k × 6 dB.
- R8: After every step the code is raised to `lim_lo` if it is below that limit, and then lowered to `lim_hi` if it is above that limit. When the two limits conflict, `lim_hi` wins.
- R9: With `upd_en` low, window ends leave the code unchanged.
- R10: With `en` low, the code holds, the accumulator is held at zero, and samples and window pulses have no effect.
- R11: `exp_out` equals (`exp_in_en` ? `exp_in` : 0) + (`exp_rc_en` ? `atten_code` : 0), as an unsigned sum one bit wider than `exp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Main enable of the range control |
| upd_en | input | 1 | Allows changes of the attenuator code |
| exp_in_en | input | 1 | Include input exponent in `exp_out` |
| exp_rc_en | input | 1 | Include attenuator code in `exp_out` |
| shift_sel | input | SHIFT_W | Normalization shift select |
| thr_hi | input | LVL_W | Upper level threshold |
| thr_lo | input | LVL_W | Lower level threshold |
| lim_hi | input | CODE_W | Highest allowed attenuator code |
| lim_lo | input | CODE_W | Lowest allowed attenuator code |
| win_start | input | 1 | First cycle of an integration window |
| win_end | input | 1 | Last cycle of an integration window |
| mag | input | MAG_W | Magnitude sample |
| mag_valid | input | 1 | Sample valid |
| exp_in | input | EXP_W | Exponent from the input stage |
| atten_code | output | CODE_W | Attenuator code, 6 dB per step |
| exp_out | output | EXP_W+1 | Combined exponent to the channel |

## Verification
The bench builds the block with ACC_W = 20 and keeps every other default. With this width, a window of 17 full-scale samples reaches accumulator saturation, so the no-wrap rule can be tested in a short run. With the 4-bit shift set to 0, a sum of 2^17 overflows the 16-bit level, which tests level saturation. With the shift set to 15, small sample counts give integer levels that can be set against the thresholds.

// File: rtl/mag_atten_pkg.sv
package mag_atten_pkg;
    localparam int MAG_W_DEF   = 16;
    localparam int ACC_W_DEF   = 32;
    localparam int LVL_W_DEF   = 16;
    localparam int SHIFT_W_DEF = 4;
    localparam int CODE_W_DEF  = 3;
    localparam int EXP_W_DEF   = 4;

    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_UP   = 2'd1,
        DEC_DOWN = 2'd2
    } step_dec_e;
endpackage

// File: rtl/mag_accum.sv
module mag_accum #(
    parameter int MAG_W = mag_atten_pkg::MAG_W_DEF,
    parameter int ACC_W = mag_atten_pkg::ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             win_start,
    input  logic [MAG_W-1:0] mag,
    input  logic             mag_valid,
    output logic [ACC_W-1:0] sum_now
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] base_d;
    logic [ACC_W:0]   wide_d;

    always_comb begin
        st_d   = st_q;
        base_d = win_start ? '0 : st_q.acc;
        wide_d = {1'b0, base_d} + (mag_valid ? {{(ACC_W+1-MAG_W){1'b0}}, mag} : '0);
        sum_now = wide_d[ACC_W] ? {ACC_W{1'b1}} : wide_d[ACC_W-1:0];
        st_d.acc = en ? sum_now : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a running sum only grows inside a window
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && !win_start) |-> (st_q.acc >= $past(st_q.acc)));
    // R2: start without a valid sample leaves zero
    a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win_start && !mag_valid) |-> (st_q.acc == '0));
    // R10: disabled control keeps the sum cleared
    a_r10_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> (st_q.acc == '0));
endmodule

// File: rtl/norm_slice.sv
module norm_slice #(
    parameter int ACC_W   = mag_atten_pkg::ACC_W_DEF,
    parameter int LVL_W   = mag_atten_pkg::LVL_W_DEF,
    parameter int SHIFT_W = mag_atten_pkg::SHIFT_W_DEF
) (
    input  logic [ACC_W-1:0]   sum_in,
    input  logic [SHIFT_W-1:0] shift_sel,
    output logic [LVL_W-1:0]   level
);
    localparam int SHW = $clog2(ACC_W + 1) + 1;

    logic [ACC_W-1:0] shifted;
    logic [SHW-1:0]   amount;

    always_comb begin
        amount  = SHW'(shift_sel) + SHW'(1);
        shifted = sum_in >> amount;
        if ((shifted >> LVL_W) != '0) level = {LVL_W{1'b1}};
        else                          level = shifted[LVL_W-1:0];
    end
endmodule

// File: rtl/atten_stepper.sv
module atten_stepper #(
    parameter int LVL_W  = mag_atten_pkg::LVL_W_DEF,
    parameter int CODE_W = mag_atten_pkg::CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              upd_en,
    input  logic              win_end,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  thr_hi,
    input  logic [LVL_W-1:0]  thr_lo,
    input  logic [CODE_W-1:0] lim_hi,
    input  logic [CODE_W-1:0] lim_lo,
    output logic [CODE_W-1:0] code_q
);
    import mag_atten_pkg::*;

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } step_state_t;

    step_state_t       st_d, st_q;
    step_dec_e         dec_d;
    logic [CODE_W-1:0] stepped_d;
    logic [CODE_W-1:0] clamped_d;
    logic              commit_d;

    always_comb begin
        st_d = st_q;
        if (level > thr_hi)      dec_d = DEC_UP;
        else if (level < thr_lo) dec_d = DEC_DOWN;
        else                     dec_d = DEC_HOLD;

        stepped_d = st_q.code;
        if (dec_d == DEC_UP && st_q.code != CODE_MAX)  stepped_d = st_q.code + 1'b1;
        if (dec_d == DEC_DOWN && st_q.code != '0)      stepped_d = st_q.code - 1'b1;

        clamped_d = stepped_d;
        if (clamped_d < lim_lo) clamped_d = lim_lo;
        if (clamped_d > lim_hi) clamped_d = lim_hi;

        commit_d = en && upd_en && win_end;
        if (commit_d) st_d.code = clamped_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_q = st_q.code;

    // R8: after an update the code never exceeds the upper limit
    a_r8_upper_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && upd_en && win_end) |-> (st_q.code <= $past(lim_hi)));
    // R9 / R10: code only moves after an enabled window end
    a_r9_change_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code != $past(st_q.code)) |-> $past(en && upd_en && win_end));
    // R5: level above upper threshold never lowers a code inside limits
    a_r5_no_drop_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && upd_en && win_end && level > thr_hi && code_q <= lim_hi)
        |-> (st_q.code >= $past(st_q.code)));
endmodule

// File: rtl/mag_atten_ctrl.sv
module mag_atten_ctrl #(
    parameter int MAG_W   = mag_atten_pkg::MAG_W_DEF,
    parameter int ACC_W   = mag_atten_pkg::ACC_W_DEF,
    parameter int LVL_W   = mag_atten_pkg::LVL_W_DEF,
    parameter int SHIFT_W = mag_atten_pkg::SHIFT_W_DEF,
    parameter int CODE_W  = mag_atten_pkg::CODE_W_DEF,
    parameter int EXP_W   = mag_atten_pkg::EXP_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               upd_en,
    input  logic               exp_in_en,
    input  logic               exp_rc_en,
    input  logic [SHIFT_W-1:0] shift_sel,
    input  logic [LVL_W-1:0]   thr_hi,
    input  logic [LVL_W-1:0]   thr_lo,
    input  logic [CODE_W-1:0]  lim_hi,
    input  logic [CODE_W-1:0]  lim_lo,
    input  logic               win_start,
    input  logic               win_end,
    input  logic [MAG_W-1:0]   mag,
    input  logic               mag_valid,
    input  logic [EXP_W-1:0]   exp_in,
    output logic [CODE_W-1:0]  atten_code,
    output logic [EXP_W:0]     exp_out
);
    localparam int OUT_W = EXP_W + 1;

    logic [ACC_W-1:0] sum_now;
    logic [LVL_W-1:0] level;
    logic [OUT_W-1:0] exp_part_d;
    logic [OUT_W-1:0] code_part_d;

    mag_accum #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .en(en), .win_start(win_start),
        .mag(mag), .mag_valid(mag_valid), .sum_now(sum_now)
    );

    norm_slice #(.ACC_W(ACC_W), .LVL_W(LVL_W), .SHIFT_W(SHIFT_W)) u_slice (
        .sum_in(sum_now), .shift_sel(shift_sel), .level(level)
    );

    atten_stepper #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_step (
        .clk(clk), .rst_n(rst_n), .en(en), .upd_en(upd_en), .win_end(win_end),
        .level(level), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .code_q(atten_code)
    );

    always_comb begin
        exp_part_d  = exp_in_en ? OUT_W'(exp_in) : '0;
        code_part_d = exp_rc_en ? OUT_W'(atten_code) : '0;
        exp_out     = exp_part_d + code_part_d;
    end

    // R11: with both addends disabled the exponent is zero
    a_r11_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!exp_in_en && !exp_rc_en) |-> (exp_out == '0));
    // R11: code alone passes straight through
    a_r11_exp_code_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!exp_in_en && exp_rc_en) |-> (exp_out == OUT_W'(atten_code)));
endmodule

// File: tb/mag_atten_ctrl_test.sv
module mag_atten_ctrl_test;
    localparam int ACC_W = 20;

    logic        clk = 0, rst_n = 0;
    logic        en = 0, upd_en = 0, exp_in_en = 0, exp_rc_en = 0;
    logic [3:0]  shift_sel = 0;
    logic [15:0] thr_hi = 0, thr_lo = 0;
    logic [2:0]  lim_hi = 7, lim_lo = 0;
    logic        win_start = 0, win_end = 0, mag_valid = 0;
    logic [15:0] mag = 0;
    logic [3:0]  exp_in = 0;
    logic [2:0]  atten_code;
    logic [4:0]  exp_out;

    int checks = 0, fails = 0;
    int mc = 0;
    bit done = 0;

    mag_atten_ctrl #(.ACC_W(ACC_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .upd_en(upd_en),
        .exp_in_en(exp_in_en), .exp_rc_en(exp_rc_en), .shift_sel(shift_sel),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .lim_hi(lim_hi), .lim_lo(lim_lo),
        .win_start(win_start), .win_end(win_end), .mag(mag),
        .mag_valid(mag_valid), .exp_in(exp_in), .atten_code(atten_code),
        .exp_out(exp_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int level_of(input longint sum);
        longint s = sum >> (shift_sel + 1);
        return (s > 65535) ? 65535 : int'(s);
    endfunction

    function automatic int next_code(input int lvl);
        int c = mc;
        if (!en || !upd_en) return mc;
        if (lvl > thr_hi) c = (mc == 7) ? 7 : mc + 1;
        else if (lvl < thr_lo) c = (mc == 0) ? 0 : mc - 1;
        if (c < lim_lo) c = lim_lo;
        if (c > lim_hi) c = lim_hi;
        return c;
    endfunction

    task automatic run_win(input int n, input logic [15:0] v, input bit gap, input string req);
        longint sum = 0;
        longint amax = (longint'(1) << ACC_W) - 1;
        for (int i = 0; i < n; i++) begin
            win_start = (i == 0);
            win_end   = (i == n - 1);
            mag       = v;
            mag_valid = gap ? (i % 2 == 0) : 1'b1;
            if (mag_valid) sum += v;
            @(negedge clk);
        end
        win_start = 0; win_end = 0; mag_valid = 0;
        if (sum > amax) sum = amax;
        if (en) mc = next_code(level_of(sum));
        check(req, atten_code, mc);
    endtask

    task automatic t_reset();
        check("R1 code", atten_code, 0);
        exp_in = 9; exp_in_en = 0; exp_rc_en = 0; #1;
        check("R1 exp", exp_out, 0);
    endtask

    task automatic t_step();
        en = 1; upd_en = 1; shift_sel = 15; thr_hi = 3; thr_lo = 1;
        run_win(8, 16'hFFFF, 0, "R5 up");
        check("R5 one step", atten_code, 1);
        run_win(4, 16'hC000, 0, "R6 hold");
        check("R6 hold value", atten_code, 1);
        run_win(2, 16'h0100, 0, "R6 down");
        check("R6 down value", atten_code, 0);
        run_win(2, 16'h0100, 0, "R7 floor");
        check("R7 floor value", atten_code, 0);
    endtask

    task automatic t_gaps();
        run_win(8, 16'hFFFF, 1, "R2 valid-only");
        run_win(8, 16'hFFFF, 0, "R2 restart");
        run_win(2, 16'h0010, 0, "R2 cleared at start");
    endtask

    task automatic t_ceiling();
        for (int k = 0; k < 9; k++) run_win(8, 16'hFFFF, 0, "R7 ceiling");
        check("R7 top", atten_code, 7);
    endtask

    task automatic t_limits();
        lim_hi = 4;
        run_win(4, 16'hC000, 0, "R8 clamp high");
        lim_lo = 5; lim_hi = 4;
        run_win(2, 16'h0100, 0, "R8 upper wins");
        check("R8 conflict value", atten_code, 4);
        lim_lo = 2; lim_hi = 7;
        run_win(2, 16'h0100, 0, "R8 down");
        run_win(2, 16'h0100, 0, "R8 at low");
        run_win(2, 16'h0100, 0, "R8 low bound");
        check("R8 lower value", atten_code, 2);
        lim_lo = 0;
    endtask

    task automatic t_freeze();
        upd_en = 0;
        run_win(8, 16'hFFFF, 0, "R9 frozen");
        check("R9 frozen value", atten_code, 2);
        upd_en = 1;
    endtask

    task automatic t_disable();
        en = 0;
        run_win(8, 16'hFFFF, 0, "R10 off");
        check("R10 off value", atten_code, 2);
        en = 1;
        // lone window end: the sum left from the disabled period must be zero
        win_end = 1; @(negedge clk); win_end = 0;
        mc = next_code(0);
        check("R10 sum cleared", atten_code, 1);
    endtask

    task automatic t_sat();
        thr_hi = 14; thr_lo = 1;
        run_win(17, 16'hFFFF, 0, "R3 saturate");
        check("R3 value", atten_code, 2);
        run_win(40, 16'hFFFF, 0, "R3 long");
    endtask

    task automatic t_slice();
        shift_sel = 0; thr_hi = 100; thr_lo = 50;
        run_win(2, 16'h0040, 0, "R4 shift0 hold");
        run_win(2, 16'h0080, 0, "R4 shift0 up");
        shift_sel = 3;
        run_win(2, 16'h0080, 0, "R4 shift3 down");
        shift_sel = 0; thr_hi = 16'hFFFE; thr_lo = 0;
        run_win(4, 16'h8000, 0, "R4 level saturate");
    endtask

    task automatic t_exp();
        exp_in = 5;
        exp_in_en = 1; exp_rc_en = 1; #1;
        check("R11 both", exp_out, 5 + mc);
        exp_in_en = 1; exp_rc_en = 0; #1;
        check("R11 input only", exp_out, 5);
        exp_in_en = 0; exp_rc_en = 1; #1;
        check("R11 code only", exp_out, mc);
        exp_in_en = 0; exp_rc_en = 0; #1;
        check("R11 none", exp_out, 0);
        exp_in = 15; exp_in_en = 1; exp_rc_en = 1; #1;
        check("R11 max", exp_out, 15 + mc);
    endtask

    initial begin
        for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_step();
        t_gaps();
        t_ceiling();
        t_limits();
        t_freeze();
        t_disable();
        t_sat();
        t_slice();
        t_exp();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule